// File: doc/BRIEF.md
# Burst/Ready Credit Flow Controller

This block sits on the sending side of a point-to-point link and keeps track of how many bursts the far end can still accept. Each READY pulse from the far end grants one credit. Each burst that leaves uses one credit. Two wrapping counters hold the running totals, and their modular difference is the number of outstanding credits. A small state machine classifies that difference. It drives a transfer-enable level, which gates the start of a new burst, and a data-request level, which goes to the host.

While the link is down, both totals are held at zero. Counting resumes on the first connected cycle. The outstanding count is capped at 2^W-1. When that limit is reached, the READY total stops advancing and further READY pulses are dropped. Bursts are still counted, so one burst reopens room for one READY.

The state machine has four states. OFFLINE means the link is down. STARVED means connected with no credit. CREDITED means connected with between 1 and 2^W-2 credits. SATURATED means connected with exactly 2^W-1 credits. A drop of `link_up` moves any state to OFFLINE. The other transitions are:

- connect: OFFLINE to STARVED, or OFFLINE to CREDITED if a READY arrives in the same cycle.
- grant: STARVED to CREDITED.
- fill: CREDITED to SATURATED.
- drain: SATURATED to CREDITED.
- spend: CREDITED to STARVED.

Top module: `fc_credit_ctrl`

## Requirements
- R1: After reset, `xfer_en` is 0, `data_req` is 0 and `credits` is 0.
- R2: In any cycle where `link_up` is sampled low, both totals clear. `credits` reads 0 from the next cycle on. READY and burst pulses in that cycle are not counted.
- R3: A READY pulse without a burst pulse, sampled while connected and with `credits` below 2^W-1, raises `credits` by exactly 1 in the next cycle.
- R4: A burst pulse without a READY pulse, sampled while connected, lowers `credits` by exactly 1 in the next cycle.
- R5: A READY pulse and a burst pulse in the same connected cycle leave `credits` unchanged, as long as `credits` is below 2^W-1.
- R6: While connected with `credits` equal to 0, `xfer_en` and `data_req` are both 0.
- R7: While connected with `credits` anywhere from 1 to 2^W-1, `xfer_en` and `data_req` are both 1.
- R8: When `credits` equals 2^W-1, a READY pulse is dropped and not queued. A READY alone leaves `credits` at 2^W-1. A READY together with a burst gives 2^W-2.
- R9: `data_req` and `xfer_en` are 0 in every cycle that follows a cycle with `link_up` low.
- R10: `credits` is the difference of the totals modulo 2^W. A total that wraps past 2^W-1 does not disturb the credit count or the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | High while the connection is established |
| ready_pulse | input | 1 | One-cycle READY received from the far end |
| burst_pulse | input | 1 | One-cycle pulse for each burst sent |
| xfer_en | output | 1 | High when a new burst may start |
| data_req | output | 1 | Request level to the host: connected and credit available |
| credits | output | CNT_W | Outstanding credits (READY total minus burst total, modulo 2^CNT_W) |

## Verification
The checker assumes the sender obeys the gate: a burst pulse appears only in cycles where `xfer_en` is high. It flags a violation of that rule as an input error. The bench's driver tracks the expected credit count and issues burst pulses only when that count is nonzero. It fills the link to saturation with 2^16-1 READY pulses. At the cap, it applies READY alone, READY together with a burst, and a burst followed by further READY pulses, which forces the READY total to wrap.

// File: rtl/fc_credit_pkg.sv
package fc_credit_pkg;

    typedef enum logic [1:0] {
        ST_OFFLINE   = 2'd0,
        ST_STARVED   = 2'd1,
        ST_CREDITED  = 2'd2,
        ST_SATURATED = 2'd3
    } fc_state_e;

    localparam int unsigned FC_NUM_CNT = 2;
    localparam int unsigned FC_IDX_RDY = 0;
    localparam int unsigned FC_IDX_BST = 1;

endpackage

// File: rtl/fc_event_counter.sv
module fc_event_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d
);

    localparam logic [W-1:0] STEP = W'(1);

    // next value: clear wins, otherwise wrapping increment
    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + STEP;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/fc_credit_fsm.sv
module fc_credit_fsm
    import fc_credit_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link_up,
    input  logic [W-1:0] rdy_nxt,
    input  logic [W-1:0] bst_nxt,
    output fc_state_e    state_q,
    output logic         rdy_gate,
    output logic         xfer_en,
    output logic         data_req
);

    localparam logic [W-1:0] CAP = {W{1'b1}};

    fc_state_e   state_d;
    logic [W-1:0] diff_nxt;
    logic         nxt_zero;
    logic         nxt_full;

    assign diff_nxt = rdy_nxt - bst_nxt;
    assign nxt_zero = (diff_nxt == '0);
    assign nxt_full = (diff_nxt == CAP);

    // next-state selection, transitions named per state
    always_comb begin
        state_d = state_q;
        if (!link_up) begin
            state_d = ST_OFFLINE;                       // disconnect
        end else begin
            unique case (state_q)
                ST_OFFLINE: begin                       // connect
                    state_d = nxt_zero ? ST_STARVED : ST_CREDITED;
                end
                ST_STARVED: begin                       // grant
                    if (!nxt_zero) state_d = ST_CREDITED;
                end
                ST_CREDITED: begin                      // fill / spend
                    if (nxt_full)      state_d = ST_SATURATED;
                    else if (nxt_zero) state_d = ST_STARVED;
                end
                ST_SATURATED: begin                     // drain
                    if (!nxt_full) state_d = ST_CREDITED;
                end
                default: state_d = ST_OFFLINE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFFLINE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        xfer_en  = 1'b0;
        data_req = 1'b0;
        rdy_gate = 1'b1;
        unique case (state_q)
            ST_OFFLINE: begin
                rdy_gate = 1'b1;
            end
            ST_STARVED: begin
                rdy_gate = 1'b1;
            end
            ST_CREDITED: begin
                xfer_en  = 1'b1;
                data_req = 1'b1;
            end
            ST_SATURATED: begin
                xfer_en  = 1'b1;
                data_req = 1'b1;
                rdy_gate = 1'b0;
            end
            default: begin
                rdy_gate = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fc_credit_ctrl.sv
module fc_credit_ctrl
    import fc_credit_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             ready_pulse,
    input  logic             burst_pulse,
    output logic             xfer_en,
    output logic             data_req,
    output logic [CNT_W-1:0] credits
);

    fc_state_e        state_q;
    logic             rdy_gate;
    logic             clr_all;
    logic [FC_NUM_CNT-1:0] inc_v;
    logic [CNT_W-1:0] cnt_q [FC_NUM_CNT];
    logic [CNT_W-1:0] cnt_d [FC_NUM_CNT];

    assign clr_all              = !link_up;
    assign inc_v[FC_IDX_RDY]    = ready_pulse && rdy_gate;
    assign inc_v[FC_IDX_BST]    = burst_pulse;

    generate
        for (genvar gi = 0; gi < FC_NUM_CNT; gi++) begin : g_cnt
            fc_event_counter #(
                .W (CNT_W)
            ) i_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr_all),
                .inc   (inc_v[gi]),
                .cnt_q (cnt_q[gi]),
                .cnt_d (cnt_d[gi])
            );
        end
    endgenerate

    fc_credit_fsm #(
        .W (CNT_W)
    ) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_up  (link_up),
        .rdy_nxt  (cnt_d[FC_IDX_RDY]),
        .bst_nxt  (cnt_d[FC_IDX_BST]),
        .state_q  (state_q),
        .rdy_gate (rdy_gate),
        .xfer_en  (xfer_en),
        .data_req (data_req)
    );

    assign credits = cnt_q[FC_IDX_RDY] - cnt_q[FC_IDX_BST];

endmodule

// File: rtl/fc_credit_chk.sv
module fc_credit_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_up,
    input logic             ready_pulse,
    input logic             burst_pulse,
    input logic             xfer_en,
    input logic             data_req,
    input logic [CNT_W-1:0] credits
);

    localparam logic [CNT_W-1:0] CAP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2
    clear_on_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (credits == '0));

    // R3
    ready_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && ready_pulse && !burst_pulse && credits != CAP)
        |=> (credits == $past(credits) + ONE));

    // R4
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && burst_pulse && !ready_pulse)
        |=> (credits == $past(credits) - ONE));

    // R6
    starved_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> ((credits == '0) == !xfer_en));

    // R7
    req_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> ((credits != '0) == data_req));

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && credits == CAP && ready_pulse && !burst_pulse)
        |=> (credits == CAP));

    // R9
    down_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!data_req && !xfer_en));

    // R7 input rule: bursts start only when enabled
    burst_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_pulse |-> xfer_en);

endmodule

bind fc_credit_ctrl fc_credit_chk #(
    .CNT_W (CNT_W)
) i_fc_credit_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_up     (link_up),
    .ready_pulse (ready_pulse),
    .burst_pulse (burst_pulse),
    .xfer_en     (xfer_en),
    .data_req    (data_req),
    .credits     (credits)
);

// File: tb/test_fc_credit_ctrl.sv
`timescale 1ns/1ps
module test_fc_credit_ctrl;

    localparam int unsigned W = 16;
    localparam logic [W-1:0] CAPV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         link_up = 1'b0;
    logic         ready_pulse = 1'b0;
    logic         burst_pulse = 1'b0;
    logic         xfer_en;
    logic         data_req;
    logic [W-1:0] credits;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic         en;
        logic         req;
        logic [W-1:0] cr;
        string        tag;
    } exp_t;

    exp_t exp_q[$];

    logic [W-1:0] m_rdy = '0;
    logic [W-1:0] m_bst = '0;

    always #4 clk = ~clk;

    fc_credit_ctrl #(.CNT_W(W)) i_fc_credit_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_up     (link_up),
        .ready_pulse (ready_pulse),
        .burst_pulse (burst_pulse),
        .xfer_en     (xfer_en),
        .data_req    (data_req),
        .credits     (credits)
    );

    task automatic compare(input exp_t e);
        n_chk++;
        if (xfer_en !== e.en || data_req !== e.req || credits !== e.cr) begin
            n_bad++;
            $display("FAIL %s: en/req/credits got %0b/%0b/%0d expected %0b/%0b/%0d",
                     e.tag, xfer_en, data_req, credits, e.en, e.req, e.cr);
        end
    endtask

    // driver: one cycle of stimulus plus the expected result
    task automatic step(input bit lk, input bit rd, input bit bs, input string tag);
        exp_t e;
        logic [W-1:0] d;
        @(negedge clk);
        link_up     = lk;
        ready_pulse = rd;
        burst_pulse = bs;
        if (!lk) begin
            m_rdy = '0;
            m_bst = '0;
        end else begin
            d = m_rdy - m_bst;
            if (rd && d != CAPV) m_rdy = m_rdy + 1'b1;
            if (bs) m_bst = m_bst + 1'b1;
        end
        e.cr  = m_rdy - m_bst;
        e.en  = lk && (e.cr != '0);
        e.req = e.en;
        e.tag = tag;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r.en = 1'b0; r.req = 1'b0; r.cr = '0; r.tag = "R1 reset";
        compare(r);

        // R2: events while down are ignored
        step(0, 1, 0, "R2 ready while down");
        step(0, 1, 0, "R2 ready while down");
        // R6: connected, no credit
        step(1, 0, 0, "R6 connected starved");
        // R3 / R7
        step(1, 1, 0, "R3 ready grants");
        step(1, 1, 0, "R3 ready grants");
        step(1, 1, 0, "R7 credited");
        step(1, 0, 1, "R4 burst spends");
        step(1, 1, 1, "R5 simultaneous");
        step(1, 0, 0, "R7 idle credited");
        step(1, 0, 1, "R4 burst spends");
        step(1, 0, 1, "R6 spent to zero");
        step(1, 0, 0, "R6 stays starved");
        // disconnect with credit outstanding
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R3 refill");
        step(0, 1, 0, "R2 clear on down");
        step(0, 0, 0, "R9 no request while down");
        // connect with a READY in the same cycle
        step(1, 1, 0, "R3 ready on connect");
        // fill to the cap
        for (int i = 1; i < 65535; i++) step(1, 1, 0, "R7 filling");
        step(1, 0, 0, "R7 saturated enabled");
        step(1, 1, 0, "R8 ready dropped at cap");
        step(1, 1, 1, "R8 ready+burst at cap");
        step(1, 1, 0, "R10 ready wraps total");
        step(1, 0, 1, "R4 burst after wrap");
        step(1, 1, 0, "R10 refill after wrap");
        step(1, 1, 0, "R8 dropped again");
        for (int i = 0; i < 4; i++) step(1, 0, 1, "R4 drain");
        step(0, 0, 0, "R9 drop from saturation");
        step(1, 0, 0, "R6 reconnect empty");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule